// File: doc/BRIEF.md
# Gated-Entry Serial-In Parallel-Out Shift Register

This block is a chain of flip-flops that accepts one serial bit per rising clock edge and shows every stage at once on a parallel output bus. The bit that enters the first stage is formed from two serial data inputs combined by AND. Holding either input low therefore blocks the other input and pushes a zero into the chain, and holding one input high lets the other carry the data.

An active-low clear empties the whole chain immediately, without waiting for a clock edge. While clear is held, it overrides the clock. The first rising edge after clear is released shifts normally into the all-zero chain. The stage count and the number of gated entry inputs are parameters. The top-level ports are fixed at two serial inputs, and the default chain length is eight.

Top module: `gated_sipo_shifter`

## Requirements
- R1: The register has STAGES stages (default 8), and bit k of `par_q` is the content of stage k. Stage 0 is the entry stage and stage STAGES-1 is the last stage.
- R2: On each rising edge of `clk` with `clear_n` high, stage 0 loads `ser_a` AND `ser_b`, using the values present at that edge.
- R3: If `ser_a` or `ser_b` is low at a rising edge, stage 0 becomes 0.
- R4: While one serial input is high at a rising edge, stage 0 takes the value of the other serial input.
- R5: On each rising edge, stage k+1 takes the previous value of stage k for k from 0 to STAGES-2. The previous value of the last stage is lost.
- R6: State changes only on rising edges of `clk`. Toggling `ser_a` or `ser_b` between edges has no effect on `par_q` until the next rising edge.
- R7: Driving `clear_n` low forces every bit of `par_q` to 0 at once, with no clock edge needed.
- R8: While `clear_n` is low, `par_q` stays 0 whatever `clk`, `ser_a` and `ser_b` do.
- R9: On the first rising edge after `clear_n` returns high, `par_q` becomes {0,…,0, `ser_a` AND `ser_b`}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the chain acts on the rising edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| ser_a | input | 1 | First gated serial data input |
| ser_b | input | 1 | Second gated serial data input |
| par_q | output | STAGES | Parallel view of all stages; bit 0 is the entry stage |

## Verification
A wrong stage value is visible on `par_q` right away, because every stage is a port. A wrong bit then walks one position per edge until it drops off the far end, so a fault in the gate or in the link between two stages shows within one edge and stays visible for up to STAGES edges. A clear that acts late or only on a clock edge shows as a nonzero `par_q` in the gap between a falling `clear_n` and the next edge. The bench therefore samples in that gap, and it also samples after glitches on the serial inputs placed between edges.

// File: rtl/gsr_pkg.sv
`timescale 1ns/1ps
package gsr_pkg;

   // Stage count used when a parent does not override it.
   localparam int unsigned GSR_DEFAULT_STAGES = 8;

   // Gated entry: the AND of all serial inputs, computed bit by bit.
   function automatic logic gsr_gate_and(input logic [15:0] bits, input int unsigned n);
      logic acc;
      acc = 1'b1;
      for (int unsigned i = 0; i < 16; i++) begin
         if (i < n) acc = acc & bits[i];
      end
      return acc;
   endfunction

endpackage

// File: rtl/gsr_entry_gate.sv
`timescale 1ns/1ps
module gsr_entry_gate #(
   parameter int unsigned GATE_INPUTS = 2
) (
   input  logic [GATE_INPUTS-1:0] gate_in,
   output logic                   gate_out
);
   import gsr_pkg::*;

   localparam int unsigned PAD_W = 16;

   generate
      if (GATE_INPUTS < 1 || GATE_INPUTS > PAD_W) begin : g_bad_width
         $error("gsr_entry_gate: GATE_INPUTS must be 1..16");
      end

      if (GATE_INPUTS == 1) begin : g_pass
         assign gate_out = gate_in[0];
      end else begin : g_and
         logic [PAD_W-1:0] padded;
         always_comb begin
            padded = '1;
            padded[GATE_INPUTS-1:0] = gate_in;
         end
         assign gate_out = gsr_gate_and(padded, GATE_INPUTS);
      end
   endgenerate

endmodule

// File: rtl/gsr_stage.sv
`timescale 1ns/1ps
module gsr_stage (
   input  logic clk,
   input  logic clear_n,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n) q <= 1'b0;
      else          q <= d;
   end
endmodule

// File: rtl/gsr_chain.sv
`timescale 1ns/1ps
module gsr_chain #(
   parameter int unsigned STAGES = 8
) (
   input  logic              clk,
   input  logic              clear_n,
   input  logic              entry_bit,
   output logic [STAGES-1:0] taps
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_len
         $error("gsr_chain: STAGES must be at least 2");
      end

      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         logic d_k;
         if (k == 0) begin : g_head
            assign d_k = entry_bit;
         end else begin : g_link
            assign d_k = taps[k-1];
         end
         gsr_stage i_stage (
            .clk     (clk),
            .clear_n (clear_n),
            .d       (d_k),
            .q       (taps[k])
         );
      end
   endgenerate

   // Set by any clear, dropped by the next clean edge: marks an edge
   // interval that was interrupted by clear.
   logic clr_seen;
   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n) clr_seen <= 1'b1;
      else          clr_seen <= 1'b0;
   end

   AST_SHIFT_LINK: assert property (@(posedge clk) disable iff (!clear_n)
      1'b1 |=> (clr_seen || taps[LAST:1] == $past(taps[LAST-1:0]))); // R5

   AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (!clear_n)
      1'b1 |=> (clr_seen || taps[0] == $past(entry_bit))); // R2

endmodule

// File: rtl/gated_sipo_shifter.sv
`timescale 1ns/1ps
module gated_sipo_shifter #(
   parameter int unsigned STAGES = gsr_pkg::GSR_DEFAULT_STAGES
) (
   input  logic              clk,
   input  logic              clear_n,
   input  logic              ser_a,
   input  logic              ser_b,
   output logic [STAGES-1:0] par_q
);
   localparam int unsigned GATE_N = 2;

   logic [GATE_N-1:0] ser_vec;
   logic              entry_bit;

   assign ser_vec = {ser_b, ser_a};

   gsr_entry_gate #(.GATE_INPUTS(GATE_N)) i_gate (
      .gate_in  (ser_vec),
      .gate_out (entry_bit)
   );

   gsr_chain #(.STAGES(STAGES)) i_chain (
      .clk       (clk),
      .clear_n   (clear_n),
      .entry_bit (entry_bit),
      .taps      (par_q)
   );

   // Tracks whether a clear occurred since the last rising edge.
   logic clr_gap;
   always_ff @(posedge clk or negedge clear_n) begin
      if (!clear_n) clr_gap <= 1'b1;
      else          clr_gap <= 1'b0;
   end

   AST_BLOCKED_ENTRY: assert property (@(posedge clk) disable iff (!clear_n)
      (!ser_a || !ser_b) |=> (clr_gap || !par_q[0])); // R3

   AST_PASS_A: assert property (@(posedge clk) disable iff (!clear_n)
      ser_b |=> (clr_gap || par_q[0] == $past(ser_a))); // R4

   AST_PASS_B: assert property (@(posedge clk) disable iff (!clear_n)
      ser_a |=> (clr_gap || par_q[0] == $past(ser_b))); // R4

   AST_RELEASE_EDGE: assert property (@(posedge clk) disable iff (!clear_n)
      clr_gap |-> 1'b1 ##1 (clr_gap || par_q[STAGES-1:1] == '0)); // R9

   always @(posedge clk) begin
      if (!clear_n) begin
         AST_CLEAR_HOLD: assert (par_q == '0); // R8
      end
   end

endmodule

// File: tb/test_gated_sipo_shifter.sv
`timescale 1ns/1ps
module test_gated_sipo_shifter;
   localparam int unsigned N = 8;

   logic         clk = 1'b0;
   logic         clear_n = 1'b0;
   logic         ser_a = 1'b0;
   logic         ser_b = 1'b0;
   logic [N-1:0] par_q;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;
   logic [N-1:0] model = '0;

   always #4 clk = ~clk;

   gated_sipo_shifter #(.STAGES(N)) i_gated_sipo_shifter (
      .clk(clk), .clear_n(clear_n), .ser_a(ser_a), .ser_b(ser_b), .par_q(par_q)
   );

   function automatic logic [N-1:0] next_state(input logic [N-1:0] cur,
                                                input logic a, input logic b);
      return {cur[N-2:0], a & b};
   endfunction

   task automatic check(input string req, input logic [N-1:0] exp);
      n_cmp++;
      if (par_q !== exp) begin
         n_bad++;
         $display("FAIL %s: par_q=%h expected=%h at %0t", req, par_q, exp, $time);
      end
   endtask

   // Presets inputs, waits for the rising edge, samples 2 ns later.
   task automatic tick(input logic a, input logic b, input string req);
      ser_a = a;
      ser_b = b;
      @(posedge clk);
      model = next_state(model, a, b);
      #2;
      check(req, model);
   endtask

   initial begin
      int unsigned seed = 32'h5eed_0042;
      void'($urandom(seed));
      #3;
      check("R7 reset", '0);
      @(posedge clk); #2;
      check("R8 clock during clear", '0);
      clear_n = 1'b1;
      model = '0;

      tick(1, 1, "R9 first edge after release");
      tick(1, 0, "R3 b low blocks");
      tick(0, 1, "R3 a low blocks");
      tick(0, 0, "R3 both low");
      tick(1, 1, "R2 both high");
      tick(1, 0, "R4 a high, b=0");
      tick(1, 1, "R4 a high, b=1");
      tick(0, 1, "R4 b high, a=0");
      tick(1, 1, "R4 b high, a=1");
      for (int i = 0; i < N; i++) tick(0, 1, "R5 last stage discarded");
      check("R1 chain flushed to zero", '0);
      tick(1, 1, "R1 bit 0 is entry");
      for (int i = 1; i < N; i++) tick(0, 0, "R1 bit walks to top");
      check("R1 top stage", {1'b1, {(N-1){1'b0}}});

      // Random streams, with glitching between edges.
      for (int i = 0; i < 300; i++) begin
         logic a, b;
         a = 1'($urandom());
         b = ($urandom() % 4) != 0;
         ser_a = ~a; ser_b = ~b;
         #1;
         check("R6 glitch between edges", model);
         tick(a, b, "R5 random shift");
      end

      // Clear pulse between edges.
      #1;
      clear_n = 1'b0;
      #1;
      check("R7 async clear mid-cycle", '0);
      model = '0;
      clear_n = 1'b1;
      tick(1, 1, "R9 edge after mid-cycle clear");
      tick(1, 1, "R5 shift after clear");

      // Clear held over several edges with data active.
      clear_n = 1'b0;
      #1;
      check("R7 clear while data present", '0);
      for (int i = 0; i < 4; i++) begin
         ser_a = 1'b1; ser_b = 1'b1;
         @(posedge clk); #2;
         check("R8 clear holds over edges", '0);
      end
      model = '0;
      #1;
      clear_n = 1'b1;
      tick(0, 1, "R9 release with blocked entry");
      tick(1, 1, "R9 follow-up shift");

      // Random streams with occasional mid-cycle clears.
      for (int i = 0; i < 200; i++) begin
         if ($urandom() % 17 == 0) begin
            clear_n = 1'b0;
            #1;
            check("R7 random clear", '0);
            model = '0;
            clear_n = 1'b1;
         end
         tick(1'($urandom()), 1'($urandom()), "R2 random with clears");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule